// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block collects up to 64 interrupt lines for a small service processor and merges them into one interrupt request. Every line owns four bits of state: a sticky pending flag, an enable, a mask and an in-service (response) flag. A line counts as active only when it is pending, enabled, not masked and not in service. The request output is raised whenever any line is active.

Software reaches the state through a simple single-cycle register bus. Reads return data on the cycle after the read strobe. A vector word gives the handler a ready-made dispatch address: a relocatable base plus four times the number of the lowest active line. The block has no priority levels and no fast-interrupt path. Lines must arrive already conditioned, as a level or a one-cycle pulse.

Top module: `intc_core`

## Requirements
- R1: After a synchronous reset, all pending, enable, mask, response and base registers read zero, `irq_out` is low and `bus_rdata` is zero.
- R2: A high `irq_in[i]` on a clock edge sets pending bit i at that edge. The bit stays set after the input returns low.
- R3: Pending words sit at offsets 0x10 (lines 0-31) and 0x14 (lines 32-63). Writing a one to a bit clears it and writing a zero leaves it unchanged. When an input is high in the same cycle as a clear of its bit, the bit stays set.
- R4: Enable words at 0x40/0x44, mask words at 0x50/0x54 and response words at 0x60/0x64 are plain read/write, with bit i of word n covering line 32*n+i.
- R5: `irq_out` is high one cycle after any line has its pending and enable bits set while its mask and response bits are clear. It is low otherwise. An enable of zero blocks a pending line.
- R6: A set mask bit removes its line from `irq_out` and from the vector.
- R7: A set response bit removes its line from `irq_out` and from the vector.
- R8: Offset 0x00 reads base + 4*k, where k is the lowest-numbered active line. It reads the base alone when no line is active. Writes to 0x00 have no effect.
- R9: The base word at offset 0x04 is plain read/write over all 32 bits.
- R10: A read strobe returns its data on `bus_rdata` at the next clock edge. Offsets with no register read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_in | input | NUM_LINES | Conditioned interrupt lines |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
A corrupted pending, enable, mask or response bit shows up at `irq_out` exactly one cycle after the faulty state appears. It also changes the vector read that follows, because the lowest active line moves or disappears. A wrong write decode shows up on the next read-back of the affected offset, and also of its neighbour, since a stray write lands in a register that should have stayed untouched. The ordering of the vector search is exposed by keeping two active lines in different words and then masking or retiring the lower one.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int OFF_VEC  = 'h00;
  localparam int OFF_BASE = 'h04;
  localparam int OFF_PEND = 'h10;
  localparam int OFF_EN   = 'h40;
  localparam int OFF_MASK = 'h50;
  localparam int OFF_RESP = 'h60;

  function automatic logic [ADDR_W-1:0] word_addr(input int off, input int w);
    return ADDR_W'(off + 4 * w);
  endfunction
endpackage

// File: rtl/intc_reg_bank.sv
module intc_reg_bank
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int WORDS = NUM_LINES / REG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] pend_vec,
  output logic [NUM_LINES-1:0] en_vec,
  output logic [NUM_LINES-1:0] mask_vec,
  output logic [NUM_LINES-1:0] resp_vec,
  output logic [REG_W-1:0]     base_q
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit_pend, hit_en, hit_mask, hit_resp;
    logic [REG_W-1:0] clr;

    assign hit_pend = wr && (addr == word_addr(OFF_PEND, w));
    assign hit_en   = wr && (addr == word_addr(OFF_EN, w));
    assign hit_mask = wr && (addr == word_addr(OFF_MASK, w));
    assign hit_resp = wr && (addr == word_addr(OFF_RESP, w));
    assign clr      = hit_pend ? wdata : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_vec[w*REG_W +: REG_W] <= '0;
        en_vec[w*REG_W +: REG_W]   <= '0;
        mask_vec[w*REG_W +: REG_W] <= '0;
        resp_vec[w*REG_W +: REG_W] <= '0;
      end else begin
        // a new input event wins over a clear in the same cycle
        pend_vec[w*REG_W +: REG_W] <= (pend_vec[w*REG_W +: REG_W] & ~clr)
                                      | irq_in[w*REG_W +: REG_W];
        if (hit_en)   en_vec[w*REG_W +: REG_W]   <= wdata;
        if (hit_mask) mask_vec[w*REG_W +: REG_W] <= wdata;
        if (hit_resp) resp_vec[w*REG_W +: REG_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (wr && addr == ADDR_W'(OFF_BASE)) base_q <= wdata;
  end
endmodule

// File: rtl/intc_lowest_find.sv
module intc_lowest_find #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int WORDS = NUM_LINES / REG_W
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] pend_vec,
  input  logic [NUM_LINES-1:0] en_vec,
  input  logic [NUM_LINES-1:0] mask_vec,
  input  logic [NUM_LINES-1:0] resp_vec,
  input  logic [REG_W-1:0]     base_q,
  input  logic [REG_W-1:0]     vector,
  output logic [REG_W-1:0]     rd_word
);
  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(OFF_VEC))  rd_word = vector;
    if (addr == ADDR_W'(OFF_BASE)) rd_word = base_q;
    for (int w = 0; w < WORDS; w++) begin
      if (addr == word_addr(OFF_PEND, w)) rd_word = pend_vec[w*REG_W +: REG_W];
      if (addr == word_addr(OFF_EN, w))   rd_word = en_vec[w*REG_W +: REG_W];
      if (addr == word_addr(OFF_MASK, w)) rd_word = mask_vec[w*REG_W +: REG_W];
      if (addr == word_addr(OFF_RESP, w)) rd_word = resp_vec[w*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] pend_vec, en_vec, mask_vec, resp_vec, active_vec;
  logic [REG_W-1:0]     base_q, vector, rd_word;
  logic                 any_active;
  logic [IW-1:0]        low_idx;

  intc_reg_bank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .irq_in(irq_in), .pend_vec(pend_vec), .en_vec(en_vec),
    .mask_vec(mask_vec), .resp_vec(resp_vec), .base_q(base_q)
  );

  assign active_vec = pend_vec & en_vec & ~mask_vec & ~resp_vec;

  intc_lowest_find #(.N(NUM_LINES)) u_find (
    .vec(active_vec), .found(any_active), .idx(low_idx)
  );

  assign vector = base_q + {{(REG_W-IW-2){1'b0}}, low_idx, 2'b00};

  intc_read_mux #(.NUM_LINES(NUM_LINES)) u_rmux (
    .addr(bus_addr), .pend_vec(pend_vec), .en_vec(en_vec),
    .mask_vec(mask_vec), .resp_vec(resp_vec), .base_q(base_q),
    .vector(vector), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_out <= any_active;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [REG_W-1:0]     bus_wdata,
  input logic [REG_W-1:0]     bus_rdata,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] pend_vec,
  input logic [NUM_LINES-1:0] en_vec,
  input logic [NUM_LINES-1:0] mask_vec,
  input logic [NUM_LINES-1:0] resp_vec,
  input logic [REG_W-1:0]     base_q
);
  logic [NUM_LINES-1:0] live;
  assign live = pend_vec & en_vec & ~mask_vec & ~resp_vec;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && pend_vec == '0 && bus_rdata == '0));

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    irq_in[0] |=> pend_vec[0]);

  // R3
  pend_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_PEND) && bus_wdata[0] && !irq_in[0])
    |=> !pend_vec[0]);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|(pend_vec & en_vec)));

  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (&mask_vec) |=> !irq_out);

  // R7
  resp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (&resp_vec) |=> !irq_out);

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_VEC) && live == '0)
    |=> bus_rdata == $past(base_q));
endmodule

bind intc_core intc_core_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_in(irq_in), .irq_out(irq_out), .pend_vec(pend_vec),
  .en_vec(en_vec), .mask_vec(mask_vec), .resp_vec(resp_vec),
  .base_q(base_q)
);

// File: tb/intc_core_tb.sv
`timescale 1ns/1ps
module intc_core_tb;
  localparam int NL = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_in = '0;
  logic          irq_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #10 clk = ~clk;

  intc_core #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares each read result against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    irq_in[line] = 1'b1;
    @(negedge clk);
    irq_in[line] = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s: irq_out got %b expected %b", t, irq_out, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq_out after reset");
    rd_reg(8'h10, 32'h0, "R1 pend0");
    rd_reg(8'h14, 32'h0, "R1 pend1");
    rd_reg(8'h40, 32'h0, "R1 en0");
    rd_reg(8'h54, 32'h0, "R1 mask1");
    rd_reg(8'h60, 32'h0, "R1 resp0");
    rd_reg(8'h04, 32'h0, "R1 base");
    rd_reg(8'h00, 32'h0, "R1 vector");
    // R4 plain registers
    wr_reg(8'h40, 32'hFFFF_FFFF);
    wr_reg(8'h44, 32'hFFFF_FFFF);
    rd_reg(8'h44, 32'hFFFF_FFFF, "R4 en1");
    wr_reg(8'h50, 32'hA5A5_0000);
    rd_reg(8'h50, 32'hA5A5_0000, "R4 mask0");
    wr_reg(8'h50, 32'h0);
    wr_reg(8'h64, 32'h1234_5678);
    rd_reg(8'h64, 32'h1234_5678, "R4 resp1");
    rd_reg(8'h60, 32'h0, "R4 resp0 untouched");
    wr_reg(8'h64, 32'h0);
    // R9 base
    wr_reg(8'h04, 32'h0000_1000);
    rd_reg(8'h04, 32'h0000_1000, "R9 base");
    // R2 / R5 / R8
    pulse(5);
    chk_irq(1'b1, "R5 irq from line 5");
    rd_reg(8'h10, 32'h0000_0020, "R2 pend0 sticky");
    rd_reg(8'h00, 32'h0000_1014, "R8 vector line 5");
    pulse(40);
    rd_reg(8'h14, 32'h0000_0100, "R2 pend1 line 40");
    rd_reg(8'h00, 32'h0000_1014, "R8 lowest wins");
    // R6 mask
    wr_reg(8'h50, 32'h0000_0020);
    rd_reg(8'h00, 32'h0000_10A0, "R6 vector skips masked");
    chk_irq(1'b1, "R6 line 40 still active");
    // R7 response
    wr_reg(8'h64, 32'h0000_0100);
    chk_irq(1'b0, "R7 in-service suppresses");
    rd_reg(8'h00, 32'h0000_1000, "R7 vector idle");
    wr_reg(8'h64, 32'h0);
    wr_reg(8'h50, 32'h0);
    // R3 write-one-to-clear
    wr_reg(8'h10, 32'h0000_0020);
    rd_reg(8'h10, 32'h0, "R3 pend0 cleared");
    wr_reg(8'h14, 32'h0);
    rd_reg(8'h14, 32'h0000_0100, "R3 zero write keeps");
    wr_reg(8'h14, 32'h0000_0100);
    chk_irq(1'b0, "R3 all cleared");
    rd_reg(8'h14, 32'h0, "R3 pend1 cleared");
    // R3 set wins over clear
    @(negedge clk);
    irq_in[3] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h8;
    @(negedge clk);
    irq_in[3] = 1'b0; bus_wr = 1'b0;
    rd_reg(8'h10, 32'h0000_0008, "R3 set wins");
    // R5 enable gating
    wr_reg(8'h40, 32'h0);
    chk_irq(1'b0, "R5 disabled line");
    rd_reg(8'h00, 32'h0000_1000, "R8 vector with disabled line");
    // R10 / R8 unmapped and read-only
    wr_reg(8'h30, 32'hCAFE_F00D);
    rd_reg(8'h30, 32'h0, "R10 unmapped reads zero");
    rd_reg(8'h08, 32'h0, "R10 hole reads zero");
    wr_reg(8'h00, 32'hDEAD_BEEF);
    rd_reg(8'h04, 32'h0000_1000, "R8 vector write ignored");
    rd_reg(8'h10, 32'h0000_0008, "R10 pend0 unchanged");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule